// File: doc/BRIEF.md
# Sparse Pulse-Height Readout Sequencer

This block collects the results of one detector event from a chain of multi-channel pulse-height analyzer chips and writes them as 24-bit event words into a processor-side FIFO. A start strobe captures a flat mask with one bit for each (chip, channel) pair that fired. The sequencer then visits only the flagged channels. It goes in ascending chip order and, within a chip, in ascending channel order. For each one it raises a read request carrying the chip and channel address, waits for the chain to answer with valid data, and pushes one word.

Each channel reports a high-gain and a low-gain conversion. The word carries the high-gain value unless that value sits at full scale, in which case the low-gain value goes out and a gain flag is set. The last word of the event carries an end token. After that word the sequencer raises a one-cycle done pulse, which serves as the processor's interrupt request. An event with no fired channel produces no word but still raises done.

Top module: `ph_sparse_readout`

## Requirements
- R1: Only channels whose bit is set in the captured fired mask (bit index = chip*16 + channel) produce a word, ordered by ascending bit index.
- R2: When the high-gain value is below full scale (2047), the word carries it in bits 10:0 with bit 14 at 0 and bit 11 at 0.
- R3: When the high-gain value equals 2047, the word carries the low-gain value in bits 10:0 with bit 14 at 1.
- R4: Bit 11 is 1 only when the low-gain value was substituted and is itself 2047; a saturated low-gain value alone sets nothing.
- R5: Bits 18:15 hold the channel number, bits 22:19 the chip number, and bits 13:12 are always 0.
- R6: Bit 23 is 1 on the final word of the event only, and no word is written after it.
- R7: While fifo_full is high no word is written; every fired channel is still delivered exactly once.
- R8: A word is written only in a cycle where the chain answers the current request with rd_valid.
- R9: done is high for exactly one cycle, in the cycle after the token word is written, or in the cycle after the start strobe when the mask is empty.
- R10: After reset no request, write or done is active and busy is low.
- R11: A start strobe while an event is being read is ignored, and the fired mask is only sampled with an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin reading one event; accepted only when idle |
| hit_mask | input | NCHIP*NCHAN | Fired channels, bit chip*NCHAN+channel |
| rd_req | output | 1 | Read request to the chain |
| rd_chip | output | 4 | Chip address of the request |
| rd_chan | output | 4 | Channel address of the request |
| rd_valid | input | 1 | Chain answers the current request |
| rd_hg | input | 11 | High-gain pulse height of the addressed channel |
| rd_lg | input | 11 | Low-gain pulse height of the addressed channel |
| rd_next | output | 1 | Chain may advance; current answer consumed |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | 24 | Formatted event word |
| fifo_full | input | 1 | FIFO cannot accept a word this cycle |
| busy | output | 1 | An event is in progress |
| done | output | 1 | One-cycle end-of-event pulse |

## Verification
The delicate coincidence is FIFO backpressure landing on the very cycle in which the token-bearing word is due, together with a chain that is slow to answer. The bench holds fifo_full high on two cycles out of three and, in other runs, gates rd_valid to one cycle in four, so the final word is often blocked or delayed. It judges the outcome by requiring the token word to appear exactly once, as the last captured word, with done in the following cycle and no write ever observed while full.

// File: rtl/ph_seq_pkg.sv
package ph_seq_pkg;

    localparam int PH_W     = 11;
    localparam int ADDR_W   = 4;
    localparam int WORD_W   = 24;
    localparam logic [PH_W-1:0] PH_FULL = '1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_FIN
    } seq_state_e;

    // Field order from MSB to LSB is fixed by the downstream decoder.
    typedef struct packed {
        logic              token;
        logic [ADDR_W-1:0] chip;
        logic [ADDR_W-1:0] chan;
        logic              low_gain;
        logic [1:0]        spare;
        logic              ovf;
        logic [PH_W-1:0]   ph;
    } ev_word_t;

    function automatic ev_word_t make_word(
        input logic [PH_W-1:0]   hg,
        input logic [PH_W-1:0]   lg,
        input logic [ADDR_W-1:0] chip,
        input logic [ADDR_W-1:0] chan,
        input logic              last
    );
        ev_word_t w;
        w.token = last;
        w.chip  = chip;
        w.chan  = chan;
        w.spare = 2'b00;
        if (hg == PH_FULL) begin
            w.low_gain = 1'b1;
            w.ph       = lg;
            w.ovf      = (lg == PH_FULL);
        end else begin
            w.low_gain = 1'b0;
            w.ph       = hg;
            w.ovf      = 1'b0;
        end
        return w;
    endfunction

endpackage

// File: rtl/ph_hit_picker.sv
module ph_hit_picker #(
    parameter int TOTAL = 64,
    localparam int IDX_W = $clog2(TOTAL)
) (
    input  logic [TOTAL-1:0] pending,
    output logic [IDX_W-1:0] idx,
    output logic             any,
    output logic             last
);
    // Lowest pending bit wins: chip 0 before chip 1, channel 0 first.
    always_comb begin
        idx = '0;
        for (int i = TOTAL - 1; i >= 0; i--) begin
            if (pending[i]) idx = IDX_W'(i);
        end
    end

    assign any  = |pending;
    assign last = any && ((pending & (pending - TOTAL'(1))) == '0);
endmodule

// File: rtl/ph_word_fmt.sv
module ph_word_fmt
    import ph_seq_pkg::*;
(
    input  logic [PH_W-1:0]   hg,
    input  logic [PH_W-1:0]   lg,
    input  logic [ADDR_W-1:0] chip,
    input  logic [ADDR_W-1:0] chan,
    input  logic              last,
    output logic [WORD_W-1:0] word
);
    ev_word_t w;
    always_comb w = make_word(hg, lg, chip, chan, last);
    assign word = w;
endmodule

// File: rtl/ph_sparse_readout.sv
module ph_sparse_readout
    import ph_seq_pkg::*;
#(
    parameter int NCHIP = 4,
    parameter int NCHAN = 16,
    localparam int TOTAL = NCHIP * NCHAN,
    localparam int IDX_W = $clog2(TOTAL)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [TOTAL-1:0]  hit_mask,
    output logic              rd_req,
    output logic [3:0]        rd_chip,
    output logic [3:0]        rd_chan,
    input  logic              rd_valid,
    input  logic [10:0]       rd_hg,
    input  logic [10:0]       rd_lg,
    output logic              rd_next,
    output logic              fifo_wr,
    output logic [23:0]       fifo_data,
    input  logic              fifo_full,
    output logic              busy,
    output logic              done
);
    seq_state_e       state;
    logic [TOTAL-1:0] pending;
    logic [IDX_W-1:0] cur_idx;
    logic             cur_any;
    logic             cur_last;
    logic             take;

    ph_hit_picker #(.TOTAL(TOTAL)) i_pick (
        .pending (pending),
        .idx     (cur_idx),
        .any     (cur_any),
        .last    (cur_last)
    );

    assign rd_chip = ADDR_W'(int'(cur_idx) / NCHAN);
    assign rd_chan = ADDR_W'(int'(cur_idx) % NCHAN);

    ph_word_fmt i_fmt (
        .hg   (rd_hg),
        .lg   (rd_lg),
        .chip (rd_chip),
        .chan (rd_chan),
        .last (cur_last),
        .word (fifo_data)
    );

    assign rd_req  = (state == ST_SCAN) && cur_any;
    assign take    = rd_req && rd_valid && !fifo_full;
    assign fifo_wr = take;
    assign rd_next = take;
    assign busy    = (state != ST_IDLE);
    assign done    = (state == ST_FIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            pending <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        pending <= hit_mask;
                        state   <= (|hit_mask) ? ST_SCAN : ST_FIN;
                    end
                end
                ST_SCAN: begin
                    if (take) begin
                        pending <= pending & ~(TOTAL'(1) << cur_idx);
                        if (cur_last) state <= ST_FIN;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ph_sparse_readout_chk.sv
module ph_sparse_readout_chk (
    input logic        clk,
    input logic        rst,
    input logic        rd_req,
    input logic        rd_valid,
    input logic [10:0] rd_hg,
    input logic [10:0] rd_lg,
    input logic        fifo_wr,
    input logic [23:0] fifo_data,
    input logic        fifo_full,
    input logic        done
);
    a_r7_no_write_when_full: assert property (@(posedge clk) disable iff (rst)
        fifo_full |-> !fifo_wr);

    a_r8_write_needs_answer: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |-> (rd_req && rd_valid));

    a_r5_spare_zero: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |-> (fifo_data[13:12] == 2'b00));

    a_r2_high_gain_kept: assert property (@(posedge clk) disable iff (rst)
        (fifo_wr && rd_hg != 11'h7FF) |-> (!fifo_data[14] && fifo_data[10:0] == rd_hg && !fifo_data[11]));

    a_r3_low_gain_swap: assert property (@(posedge clk) disable iff (rst)
        (fifo_wr && rd_hg == 11'h7FF) |-> (fifo_data[14] && fifo_data[10:0] == rd_lg));

    a_r6_silent_after_token: assert property (@(posedge clk) disable iff (rst)
        (fifo_wr && fifo_data[23]) |=> !fifo_wr);

    a_r9_done_after_token: assert property (@(posedge clk) disable iff (rst)
        (fifo_wr && fifo_data[23]) |=> done);

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

bind ph_sparse_readout ph_sparse_readout_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_req    (rd_req),
    .rd_valid  (rd_valid),
    .rd_hg     (rd_hg),
    .rd_lg     (rd_lg),
    .fifo_wr   (fifo_wr),
    .fifo_data (fifo_data),
    .fifo_full (fifo_full),
    .done      (done)
);

// File: tb/test_ph_sparse_readout.sv
module test_ph_sparse_readout;
    localparam int CLK_P = 10;
    localparam int NCHAN = 16;
    localparam int TOTAL = 64;
    localparam int NVEC  = 6;

    // {fired mask, high-gain saturated mask, low-gain saturated mask}
    localparam logic [191:0] VEC [NVEC] = '{
        {64'h0000_0000_0000_0001, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000},
        {64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000},
        {64'h0041_2000_0810_1004, 64'h0001_2000_0000_0004, 64'h0000_2000_0000_0000},
        {64'hFFFF_FFFF_FFFF_FFFF, 64'hF0F0_F0F0_F0F0_F0F0, 64'hC0C0_C0C0_C0C0_C0C0},
        {64'hAAAA_0000_5555_0000, 64'hFFFF_FFFF_0000_0000, 64'h8000_8000_8000_8000},
        {64'h00FF_0000_0000_FF00, 64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [TOTAL-1:0] hit_mask = '0;
    logic             rd_req;
    logic [3:0]       rd_chip;
    logic [3:0]       rd_chan;
    logic             rd_valid;
    logic [10:0]      rd_hg;
    logic [10:0]      rd_lg;
    logic             rd_next;
    logic             fifo_wr;
    logic [23:0]      fifo_data;
    logic             fifo_full = 1'b0;
    logic             busy;
    logic             done;

    logic             chip_rdy = 1'b1;
    logic [10:0]      hg_arr [TOTAL];
    logic [10:0]      lg_arr [TOTAL];

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    logic [23:0] got [TOTAL+8];
    int n_got = 0, n_done = 0, n_full_wr = 0, tok_cyc = -1, done_cyc = -1;

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign rd_valid = rd_req & chip_rdy;
    assign rd_hg    = hg_arr[int'(rd_chip) * NCHAN + int'(rd_chan)];
    assign rd_lg    = lg_arr[int'(rd_chip) * NCHAN + int'(rd_chan)];

    ph_sparse_readout i_ph_sparse_readout (
        .clk(clk), .rst(rst), .start(start), .hit_mask(hit_mask),
        .rd_req(rd_req), .rd_chip(rd_chip), .rd_chan(rd_chan),
        .rd_valid(rd_valid), .rd_hg(rd_hg), .rd_lg(rd_lg), .rd_next(rd_next),
        .fifo_wr(fifo_wr), .fifo_data(fifo_data), .fifo_full(fifo_full),
        .busy(busy), .done(done)
    );

    always @(negedge clk) begin
        if (fifo_wr) begin
            if (fifo_full) n_full_wr++;
            if (n_got < TOTAL + 8) got[n_got] = fifo_data;
            n_got++;
            if (fifo_data[23]) tok_cyc = cyc;
        end
        if (done) begin
            n_done++;
            done_cyc = cyc;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected word from R2..R6 encodings.
    function automatic logic [23:0] exp_word(input int i, input logic [10:0] hg, input logic [10:0] lg, input bit tok);
        logic [10:0] ph;
        logic g, o;
        if (hg == 11'h7FF) begin ph = lg; g = 1'b1; o = (lg == 11'h7FF); end
        else begin ph = hg; g = 1'b0; o = 1'b0; end
        return {tok, 4'(i / NCHAN), 4'(i % NCHAN), g, 2'b00, o, ph};
    endfunction

    task automatic run_event(input logic [63:0] hit, input logic [63:0] sat, input logic [63:0] lsat,
                             input bit stall, input bit slow, input bit inject);
        int k, s_cyc, ne, last_i;
        for (int i = 0; i < TOTAL; i++) begin
            hg_arr[i] = sat[i]  ? 11'h7FF : 11'(i * 29 + 3);
            lg_arr[i] = lsat[i] ? 11'h7FF : 11'(i * 7 + 1);
        end
        n_got = 0; n_done = 0; n_full_wr = 0; tok_cyc = -1; done_cyc = -1;
        @(posedge clk); #1;
        hit_mask = hit; start = 1'b1; s_cyc = cyc;
        k = 0;
        while (n_done == 0 && k < 2000) begin
            @(posedge clk); #1;
            start     = inject && (k == 2);
            hit_mask  = (inject && k == 2) ? ~hit : hit;
            fifo_full = stall && (k % 3 != 0);
            chip_rdy  = !slow || (k % 4 == 1);
            k++;
        end
        fifo_full = 1'b0; chip_rdy = 1'b1; start = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(n_done == 1, "R9 single done per event", 64'(n_done), 64'd1);
        check(n_full_wr == 0, "R7 write while full", 64'(n_full_wr), 64'd0);
        last_i = -1;
        for (int i = 0; i < TOTAL; i++) if (hit[i]) last_i = i;
        ne = 0;
        for (int i = 0; i < TOTAL; i++) begin
            if (hit[i]) begin
                if (ne < n_got && ne < TOTAL + 8)
                    check(got[ne] == exp_word(i, hg_arr[i], lg_arr[i], i == last_i),
                          "R1 R2 R3 R4 R5 R6 word", 64'(got[ne]),
                          64'(exp_word(i, hg_arr[i], lg_arr[i], i == last_i)));
                ne++;
            end
        end
        check(n_got == ne, "R1 R6 R7 word count", 64'(n_got), 64'(ne));
        if (ne == 0)
            check(done_cyc == s_cyc + 1, "R9 done timing empty", 64'(done_cyc), 64'(s_cyc + 1));
        else
            check(done_cyc == tok_cyc + 1, "R9 done timing token", 64'(done_cyc), 64'(tok_cyc + 1));
    endtask

    initial begin
        #(CLK_P * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < TOTAL; i++) begin hg_arr[i] = '0; lg_arr[i] = '0; end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(!rd_req && !fifo_wr && !done && !busy, "R10 reset state",
              64'({rd_req, fifo_wr, done, busy}), 64'd0);

        // Table walk: odd rows with FIFO backpressure, every third row with a slow chain.
        for (int v = 0; v < NVEC; v++) begin
            run_event(VEC[v][191:128], VEC[v][127:64], VEC[v][63:0], (v % 2) == 1, (v % 3) == 2, 1'b0);
        end

        // R1 R9: empty event yields no word but still signals done.
        run_event(64'h0, 64'h0, 64'h0, 1'b0, 1'b0, 1'b0);

        // R11: a second start with another mask during readout is ignored.
        run_event(64'h0300_0000_00F0_0001, 64'h0100_0000_0000_0000, 64'h0, 1'b0, 1'b0, 1'b1);

        // R7 R6: backpressure and slow chain together on a dense event.
        run_event(64'hFFFF_FFFF_FFFF_FFFF, 64'h8421_8421_8421_8421, 64'h8000_0001_8000_0001, 1'b1, 1'b1, 1'b0);

        // R8: no answer from the chain means no write.
        @(posedge clk); #1;
        chip_rdy = 1'b0; n_got = 0; n_done = 0;
        hit_mask = 64'h10; start = 1'b1;
        @(posedge clk); #1; start = 1'b0;
        repeat (5) @(posedge clk);
        #1;
        check(n_got == 0 && rd_req, "R8 no write without answer", 64'(n_got), 64'd0);
        chip_rdy = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        check(n_got == 1 && n_done == 1, "R8 write after answer", 64'({n_got[7:0], n_done[7:0]}), 64'h0101);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule